// File: doc/BRIEF.md
# Two-Level Reconfigurable Scan Gateway Network

This block is an on-chip scan network placed behind a JTAG test access port. A TAP instruction that enables the gateways drives its select input, and while that select is high the TAP's capture, shift and update strobes act on a serial path from `tdi` to `tdo`. After test reset the path holds only the fifteen cells of the top gateway, which act as a distributed instruction register. Setting a top cell and applying an update splices that cell's five-cell sub-gateway into the path. Setting a sub-gateway cell splices a local chain of four 2-bit instrument registers into the path.

So a single instrument is reached by opening the path in three update passes, one level at a time. Any mix of branches may be open together, so several instruments can be driven in the same pass. A branch whose gateway cell is clear leaves the path and keeps all of its contents. A broken local chain therefore affects only its own four instruments. A broken top cell affects only the twenty instruments below it.

The instrument side is static. Each instrument register drives two bits of `inst_ctrl` from its update stage and captures two bits of `inst_stat` into its shift stage. The port follows JTAG strobe semantics and has no valid/ready handshake. A serial scan has no back-pressure: every rising `tck` that has `shift_dr` high moves the path one position.

Top module: `sgn_scan_network`

## Requirements
- R1: After `trst_n` is released, every gateway update latch and every `inst_ctrl` bit is 0, and the path from `tdi` to `tdo` is exactly 15 cells long.
- R2: While `sel` is low, the capture, shift and update strobes have no effect. No gateway latch changes and no `inst_ctrl` bit changes.
- R3: When a top cell's update latch is set by an update pass, its 5-cell sub-gateway enters the path directly after that top cell. Latches change only on a rising `tck` with `update_dr` and `sel` both high.
- R4: A sub-gateway cell whose latch is set, and whose parent is open, splices in an 8-cell instrument chain. Setting an instrument's `inst_ctrl` from reset takes three successive update passes (top, sub, chain).
- R5: Capture behaves as follows. A gateway cell captures its own update latch. An instrument cell captures `inst_stat`. Bits then leave on `tdo` starting with the cell nearest `tdo`.
- R6: Several top and sub branches may be open at the same time. Instruments in different branches are all loaded by the same update pass.
- R7: A branch whose gateway latch is clear is out of the path. Its sub-gateway latches and `inst_ctrl` bits keep their values. When the branch is reopened, the earlier segment length returns.
- R8: Driving `trst_n` low at any time clears all latches and `inst_ctrl` at once, and returns the path to 15 cells.
- R9: After each update pass, the path length equals 15 + 5 × (open top cells) + 8 × (open sub cells whose parent top cell is open).
- R10: Path order runs from `tdi`. Top cell t comes first, then its sub-gateway if t is open, then top cell t+1. Within a sub-gateway, sub cell s comes first, then its chain if s is open. Chain position p (0 nearest `tdi`) is instrument p/2, bit p%2. That bit is `inst_ctrl`/`inst_stat` index ((t·5+s)·4 + p/2)·2 + p%2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| sel | input | 1 | Network select from the gateway-enable TAP instruction |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, taken from the last cell in the path |
| inst_stat | input | 600 | Instrument status bits, captured into the chains |
| inst_ctrl | output | 600 | Instrument control bits, taken from the chain update stages |

## Verification
On every cycle, the assertions check three things. With `sel` or `update_dr` low, no latch or control bit moves. A closed top branch freezes its sub-gateway and its instruments. An instrument chain changes only while both of its parents are open. Reset clearing is also checked on every cycle. The bench scenarios cover the rest. They show the serial path length after each pass, the order of cells in that path, the values captured on `tdo`, three-pass access to an instrument, loading several branches in one pass, and recovery of a segment's length when it is reopened. These need full scan sequences with known data and cannot be seen one cycle at a time.

// File: rtl/sgn_pkg.sv
package sgn_pkg;

  // Strobes that travel down the hierarchy with a local select.
  typedef struct packed {
    logic sel;
    logic cap;
    logic sh;
    logic upd;
  } sgn_strobe_t;

  localparam int unsigned SGN_TOP_W   = 15;
  localparam int unsigned SGN_SUB_W   = 5;
  localparam int unsigned SGN_CHAIN_N = 4;
  localparam int unsigned SGN_INST_W  = 2;

endpackage

// File: rtl/sgn_instr_chain.sv
module sgn_instr_chain
  import sgn_pkg::*;
#(
  parameter int unsigned CHAIN_N = 4,
  parameter int unsigned INST_W  = 2
) (
  input  logic                        tck,
  input  logic                        trst_n,
  input  sgn_strobe_t                 stb,
  input  logic                        si,
  output logic                        so,
  input  logic [CHAIN_N*INST_W-1:0]   stat,
  output logic [CHAIN_N*INST_W-1:0]   ctrl
);

  localparam int unsigned CW = CHAIN_N * INST_W;

  logic [CW:0] link;
  assign link[0] = si;
  assign so      = link[CW];

  // One shift-capture-update cell per chain position; position p feeds p+1.
  for (genvar p = 0; p < CW; p++) begin : g_cell
    logic sh_q;
    logic upd_q;

    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
        sh_q <= 1'b0;
      end else if (stb.sel) begin
        if (stb.cap)     sh_q <= stat[p];
        else if (stb.sh) sh_q <= link[p];
      end
    end

    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                  upd_q <= 1'b0;
      else if (stb.sel && stb.upd)  upd_q <= sh_q;
    end

    assign link[p+1] = sh_q;
    assign ctrl[p]   = upd_q;
  end

endmodule

// File: rtl/sgn_gate_cell.sv
module sgn_gate_cell
  import sgn_pkg::*;
(
  input  logic        tck,
  input  logic        trst_n,
  input  sgn_strobe_t stb,
  input  logic        si,
  output logic        so,
  output sgn_strobe_t child_stb,
  output logic        child_si,
  input  logic        child_so,
  output logic        open
);

  logic sh_q;
  logic upd_q;

  // The shift stage captures the cell's own latch so the path can be read back.
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q <= 1'b0;
    end else if (stb.sel) begin
      if (stb.cap)     sh_q <= upd_q;
      else if (stb.sh) sh_q <= si;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 upd_q <= 1'b0;
    else if (stb.sel && stb.upd) upd_q <= sh_q;
  end

  // The segment below sees the strobes only while this cell is open.
  always_comb begin
    child_stb     = stb;
    child_stb.sel = stb.sel & upd_q;
  end

  assign child_si = sh_q;
  assign so       = upd_q ? child_so : sh_q;
  assign open     = upd_q;

endmodule

// File: rtl/sgn_sub_gateway.sv
module sgn_sub_gateway
  import sgn_pkg::*;
#(
  parameter int unsigned SUB_W   = 5,
  parameter int unsigned CHAIN_N = 4,
  parameter int unsigned INST_W  = 2
) (
  input  logic                              tck,
  input  logic                              trst_n,
  input  sgn_strobe_t                       stb,
  input  logic                              si,
  output logic                              so,
  input  logic [SUB_W*CHAIN_N*INST_W-1:0]   stat,
  output logic [SUB_W*CHAIN_N*INST_W-1:0]   ctrl,
  output logic [SUB_W-1:0]                  open
);

  localparam int unsigned CW = CHAIN_N * INST_W;

  logic [SUB_W:0] link;
  assign link[0] = si;
  assign so      = link[SUB_W];

  for (genvar s = 0; s < SUB_W; s++) begin : g_sub
    sgn_strobe_t chain_stb;
    logic        chain_si;
    logic        chain_so;

    sgn_gate_cell u_gate (
      .tck       (tck),
      .trst_n    (trst_n),
      .stb       (stb),
      .si        (link[s]),
      .so        (link[s+1]),
      .child_stb (chain_stb),
      .child_si  (chain_si),
      .child_so  (chain_so),
      .open      (open[s])
    );

    sgn_instr_chain #(
      .CHAIN_N (CHAIN_N),
      .INST_W  (INST_W)
    ) u_chain (
      .tck    (tck),
      .trst_n (trst_n),
      .stb    (chain_stb),
      .si     (chain_si),
      .so     (chain_so),
      .stat   (stat[s*CW +: CW]),
      .ctrl   (ctrl[s*CW +: CW])
    );
  end

endmodule

// File: rtl/sgn_scan_network.sv
module sgn_scan_network
  import sgn_pkg::*;
#(
  parameter int unsigned TOP_W   = SGN_TOP_W,
  parameter int unsigned SUB_W   = SGN_SUB_W,
  parameter int unsigned CHAIN_N = SGN_CHAIN_N,
  parameter int unsigned INST_W  = SGN_INST_W,
  localparam int unsigned CW     = CHAIN_N * INST_W,
  localparam int unsigned GW     = SUB_W * CW,
  localparam int unsigned NB     = TOP_W * GW
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          sel,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          tdi,
  output logic          tdo,
  input  logic [NB-1:0] inst_stat,
  output logic [NB-1:0] inst_ctrl
);

  sgn_strobe_t               root_stb;
  logic [TOP_W:0]            link;
  logic [TOP_W-1:0]          top_open;
  logic [TOP_W*SUB_W-1:0]    sub_open;

  always_comb begin
    root_stb.sel = sel;
    root_stb.cap = capture_dr;
    root_stb.sh  = shift_dr;
    root_stb.upd = update_dr;
  end

  assign link[0] = tdi;
  assign tdo     = link[TOP_W];

  for (genvar t = 0; t < TOP_W; t++) begin : g_top
    sgn_strobe_t grp_stb;
    logic        grp_si;
    logic        grp_so;

    sgn_gate_cell u_gate (
      .tck       (tck),
      .trst_n    (trst_n),
      .stb       (root_stb),
      .si        (link[t]),
      .so        (link[t+1]),
      .child_stb (grp_stb),
      .child_si  (grp_si),
      .child_so  (grp_so),
      .open      (top_open[t])
    );

    sgn_sub_gateway #(
      .SUB_W   (SUB_W),
      .CHAIN_N (CHAIN_N),
      .INST_W  (INST_W)
    ) u_sub (
      .tck    (tck),
      .trst_n (trst_n),
      .stb    (grp_stb),
      .si     (grp_si),
      .so     (grp_so),
      .stat   (inst_stat[t*GW +: GW]),
      .ctrl   (inst_ctrl[t*GW +: GW]),
      .open   (sub_open[t*SUB_W +: SUB_W])
    );
  end

endmodule

// File: rtl/sgn_scan_checker.sv
module sgn_scan_checker #(
  parameter int unsigned TOP_W   = 15,
  parameter int unsigned SUB_W   = 5,
  parameter int unsigned CHAIN_N = 4,
  parameter int unsigned INST_W  = 2,
  localparam int unsigned CW     = CHAIN_N * INST_W,
  localparam int unsigned GW     = SUB_W * CW,
  localparam int unsigned NB     = TOP_W * GW
) (
  input logic                   tck,
  input logic                   trst_n,
  input logic                   sel,
  input logic                   update_dr,
  input logic [TOP_W-1:0]       top_open,
  input logic [TOP_W*SUB_W-1:0] sub_open,
  input logic [NB-1:0]          inst_ctrl
);

  p_unsel_frozen_r2: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> ($stable(top_open) && $stable(sub_open) && $stable(inst_ctrl)));

  p_update_only_r3: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> ($stable(top_open) && $stable(sub_open) && $stable(inst_ctrl)));

  always @(posedge tck) begin
    if (!trst_n) begin
      p_reset_clear_r8: assert (top_open == '0 && sub_open == '0 && inst_ctrl == '0);
    end
  end

  for (genvar t = 0; t < TOP_W; t++) begin : g_top_chk
    p_closed_branch_r7: assert property (@(posedge tck) disable iff (!trst_n)
      !top_open[t] |=> ($stable(sub_open[t*SUB_W +: SUB_W]) && $stable(inst_ctrl[t*GW +: GW])));
  end

  for (genvar g = 0; g < TOP_W*SUB_W; g++) begin : g_sub_chk
    p_chain_needs_parents_r4: assert property (@(posedge tck) disable iff (!trst_n)
      !(top_open[g/SUB_W] && sub_open[g]) |=> $stable(inst_ctrl[g*CW +: CW]));
  end

endmodule

bind sgn_scan_network sgn_scan_checker #(
  .TOP_W   (TOP_W),
  .SUB_W   (SUB_W),
  .CHAIN_N (CHAIN_N),
  .INST_W  (INST_W)
) u_sgn_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .sel       (sel),
  .update_dr (update_dr),
  .top_open  (top_open),
  .sub_open  (sub_open),
  .inst_ctrl (inst_ctrl)
);

// File: tb/test_sgn_scan_network.sv
`timescale 1ns/1ps
module test_sgn_scan_network;

  localparam int TW   = 15;
  localparam int SW   = 5;
  localparam int CW   = 8;
  localparam int NG   = TW * SW;
  localparam int NB   = NG * CW;
  localparam int MAXL = TW + NG + NB;

  logic tck = 1'b0;
  logic trst_n = 1'b1;
  logic sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NB-1:0] inst_stat, inst_ctrl;

  always #2.5 tck = ~tck;

  sgn_scan_network i_sgn_scan_network (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .inst_stat(inst_stat), .inst_ctrl(inst_ctrl)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Bench model: latched state and desired next state.
  logic [TW-1:0] m_top, d_top;
  logic [NG-1:0] m_sub, d_sub;
  logic [NB-1:0] m_ctrl, d_ctrl;
  logic [MAXL-1:0] vec, expv, got;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  function automatic int exp_len();
    int n = TW;
    for (int t = 0; t < TW; t++)
      if (m_top[t]) begin
        n += SW;
        for (int s = 0; s < SW; s++) if (m_sub[t*SW+s]) n += CW;
      end
    return n;
  endfunction

  task automatic measure_len(output int n);
    sel = 1'b1; shift_dr = 1'b1; tdi = 1'b0;
    repeat (MAXL) @(negedge tck);
    tdi = 1'b1;
    @(negedge tck);
    tdi = 1'b0;
    n = 1;
    while (tdo !== 1'b1 && n < MAXL + 4) begin
      @(negedge tck);
      n++;
    end
    shift_dr = 1'b0;
  endtask

  task automatic check_len(input string req);
    int n;
    measure_len(n);
    check(n == exp_len(), req, "path length", n, exp_len());
  endtask

  task automatic check_ctrl(input string req);
    int diff = 0;
    for (int i = 0; i < NB; i++) if (inst_ctrl[i] !== m_ctrl[i]) diff++;
    check(diff == 0, req, "inst_ctrl mismatching bits", diff, 0);
  endtask

  // One capture-shift-update pass over the current path.
  task automatic run_pass(input string req);
    int p = 0, L, bad = 0;
    for (int t = 0; t < TW; t++) begin
      vec[p] = d_top[t]; expv[p] = m_top[t]; p++;
      if (m_top[t])
        for (int s = 0; s < SW; s++) begin
          int g = t*SW + s;
          vec[p] = d_sub[g]; expv[p] = m_sub[g]; p++;
          if (m_sub[g])
            for (int b = 0; b < CW; b++) begin
              vec[p] = d_ctrl[g*CW+b]; expv[p] = inst_stat[g*CW+b]; p++;
            end
        end
    end
    L = p;
    sel = 1'b1; capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < L; i++) begin
      got[L-1-i] = tdo;
      tdi = vec[L-1-i];
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    for (int i = 0; i < L; i++) if (got[i] !== expv[i]) bad++;
    check(bad == 0, "R5", "captured bits differing", bad, 0);
    for (int t = 0; t < TW; t++)
      if (m_top[t])
        for (int s = 0; s < SW; s++) begin
          int g = t*SW + s;
          if (m_sub[g]) m_ctrl[g*CW +: CW] = d_ctrl[g*CW +: CW];
          m_sub[g] = d_sub[g];
        end
    m_top = d_top;
    check_ctrl(req);
    check_len("R9");
  endtask

  task automatic do_reset();
    @(negedge tck);
    trst_n = 1'b0;
    #1;
    m_top = '0; m_sub = '0; m_ctrl = '0;
    d_top = '0; d_sub = '0; d_ctrl = '0;
    @(negedge tck);
    trst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge tck);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) inst_stat[i] = ((i % 3) == 0) ^ ((i % 7) == 2);
    #1;
    do_reset();

    // R1: reset state
    check_ctrl("R1");
    check_len("R1");

    // R4/R3/R10: three passes down to instrument chain (3,2)
    d_top[3] = 1'b1;                     run_pass("R3");
    d_sub[3*SW+2] = 1'b1;                run_pass("R4");
    d_ctrl[(3*SW+2)*CW +: CW] = 8'hA6;   run_pass("R10");
    check(inst_ctrl[(3*SW+2)*CW +: CW] == 8'hA6, "R4", "instrument group 17",
          inst_ctrl[(3*SW+2)*CW +: CW], 8'hA6);

    // R6: two more branches opened and loaded together with group 17
    d_top[0] = 1'b1; d_top[9] = 1'b1;    run_pass("R6");
    d_sub[0] = 1'b1; d_sub[9*SW+4] = 1'b1; run_pass("R6");
    d_ctrl[0 +: CW] = 8'h3C; d_ctrl[(9*SW+4)*CW +: CW] = 8'hC5;
    d_ctrl[(3*SW+2)*CW +: CW] = 8'h5A;   run_pass("R6");
    check(inst_ctrl[0 +: CW] == 8'h3C && inst_ctrl[(9*SW+4)*CW +: CW] == 8'hC5,
          "R6", "concurrent groups", inst_ctrl[(9*SW+4)*CW +: CW], 8'hC5);

    // R2: strobes with sel low do nothing
    sel = 1'b0; capture_dr = 1'b1;
    @(negedge tck);
    capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < 40; i++) begin tdi = i[0]; @(negedge tck); end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck);
    update_dr = 1'b0;
    check_ctrl("R2");
    check_len("R2");

    // R7: close top 3, then reopen it
    d_top[3] = 1'b0;                     run_pass("R7");
    check(inst_ctrl[(3*SW+2)*CW +: CW] == 8'h5A, "R7", "closed group held",
          inst_ctrl[(3*SW+2)*CW +: CW], 8'h5A);
    d_top[3] = 1'b1;                     run_pass("R7");

    // R9/R3: sweep each top cell alone
    d_top = '0;                          run_pass("R9");
    for (int t = 0; t < TW; t++) begin
      d_top = '0; d_top[t] = 1'b1;       run_pass("R3");
    end
    // R9/R4: sweep sub cells of the last top branch
    for (int s = 0; s < SW; s++) begin
      d_sub[(TW-1)*SW+s] = 1'b1;         run_pass("R4");
    end
    for (int s = 0; s < SW; s++) d_ctrl[((TW-1)*SW+s)*CW +: CW] = 8'(s*37+11);
    run_pass("R10");

    // R8: asynchronous reset mid-run
    do_reset();
    check_ctrl("R8");
    check_len("R8");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule